// File: doc/BRIEF.md
# Ethernet MAC Control Register Front-End

This block is the software-visible register file of a small Ethernet MAC. A processor reaches it through a simple 32-bit valid/ready bus that accepts a request every cycle and returns read data one cycle later. The block holds the interrupt cause and mask registers, a port configuration bit that selects a two-byte receive offset, and the descriptor ring pointers for four receive queues and two transmit queues. It drives a level interrupt to the system.

The DMA engines sit outside. They report completed work through one-cycle strobes that set cause bits. They receive a transmit kick pulse for each priority whenever software issues a transmit command. They read the ring pointers and the receive offset from dedicated output buses.

Management reads of the PHY are answered locally. A fixed PHY model reports link up, autonegotiation capability and a fixed identifier, and no MDIO pin ever toggles.

Top module: `mac_csr_top`

## Requirements
- R1: After synchronous reset every register reads zero, `irq` is low, `rx_offset` is 0, both kick pulses are low and all pointer outputs are zero.
- R2: `req_ready` is always high. A read request (`req_valid`=1, `req_write`=0) gives `rsp_valid`=1 with its data on the following cycle, and `rsp_valid` is 0 otherwise.
- R3: The management register is at offset 0x010. A written value with bit 26 set latches a read whose address field is bits 25:16. Reads then return 0x0800000C for address 0x021, 0x08000141 for 0x041 and 0x08000E20 for 0x061; bit 27 is the read-valid flag.
- R4: With bit 26 set and any other address field value, the management register reads 0x08000000. With bit 26 clear it reads 0.
- R5: The cause register is at offset 0x450. A write ANDs it with the write data. The strobes `rx_evt`, `txhi_evt` and `txlo_evt` set bits 0, 2 and 3. All other cause bits always read 0.
- R6: A strobe arriving in the same cycle as a cause write leaves its bit set.
- R7: The mask register at 0x458 is a plain 32-bit load that reads back unchanged. `irq` equals ((cause & mask) != 0) in the same cycle, so it falls as soon as the cause bits are cleared.
- R8: Bit 28 of a write to the port configuration register at 0x408 sets `rx_offset` to 2, or to 0 when the bit is clear. The register reads 0.
- R9: The receive first pointers are at 0x480+4i and the receive current pointers at 0x4A0+4i, for i in 0..3. The transmit current pointers are at 0x4E0+4i, for i in 0..1. Each reads back its last written value and drives slice i of its output bus.
- R10: A write to the command register at 0x448 with bit 23 set pulses `tx_kick_hi` high for exactly the next cycle, and bit 22 does the same for `tx_kick_lo`. The register reads 0.
- R11: Unmapped or misaligned offsets read 0, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Always 1 |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| rx_evt | input | 1 | Receive completion strobe (cause bit 0) |
| txhi_evt | input | 1 | High-priority transmit completion strobe (cause bit 2) |
| txlo_evt | input | 1 | Low-priority transmit completion strobe (cause bit 3) |
| irq | output | 1 | Level interrupt |
| rx_offset | output | 2 | Receive buffer byte offset, 0 or 2 |
| tx_kick_hi | output | 1 | One-cycle start pulse, high-priority transmit queue |
| tx_kick_lo | output | 1 | One-cycle start pulse, low-priority transmit queue |
| rx_first_ptrs | output | 128 | Receive first pointers, queue i in bits 32i+31:32i |
| rx_cur_ptrs | output | 128 | Receive current pointers, queue i in bits 32i+31:32i |
| tx_cur_ptrs | output | 64 | Transmit current pointers, queue i in bits 32i+31:32i |

## Verification
The bench sweeps all 1024 management address values with the read opcode set. A decoder that compares too few address bits would return the identifier for aliased addresses, and one that forgets the valid flag would return a bare zero. It sets every cause pattern through the strobes and crosses it with every low mask value. A design that registers `irq`, or lets a same-cycle write-AND clear a fresh strobe, shows a stale or lost interrupt. It also writes to unmapped and misaligned offsets next to the pointer banks and checks that no pointer, mask or offset moves, which catches loose address compares.

// File: rtl/mac_csr_pkg.sv
package mac_csr_pkg;
  localparam int AW = 12;
  localparam int DW = 32;

  localparam logic [AW-1:0] OFS_MII     = 12'h010;
  localparam logic [AW-1:0] OFS_PORTCFG = 12'h408;
  localparam logic [AW-1:0] OFS_CMD     = 12'h448;
  localparam logic [AW-1:0] OFS_CAUSE   = 12'h450;
  localparam logic [AW-1:0] OFS_MASK    = 12'h458;
  localparam logic [AW-1:0] OFS_RXFIRST = 12'h480;
  localparam logic [AW-1:0] OFS_RXCUR   = 12'h4A0;
  localparam logic [AW-1:0] OFS_TXCUR   = 12'h4E0;

  localparam int MII_RD_BIT    = 26;
  localparam int MII_VLD_BIT   = 27;
  localparam int MII_ADDR_LO   = 16;
  localparam int MII_ADDR_W    = 10;
  localparam int OFFSET_SEL_BIT = 28;
  localparam int KICK_HI_BIT   = 23;
  localparam int KICK_LO_BIT   = 22;

  localparam int CAUSE_W       = 4;
  localparam int CAUSE_RX      = 0;
  localparam int CAUSE_TXHI    = 2;
  localparam int CAUSE_TXLO    = 3;

  localparam logic [MII_ADDR_W-1:0] PHY_STATUS = 10'h021;
  localparam logic [MII_ADDR_W-1:0] PHY_ID_HI  = 10'h041;
  localparam logic [MII_ADDR_W-1:0] PHY_ID_LO  = 10'h061;
  localparam logic [15:0] PHY_STATUS_VAL = 16'h000C;
  localparam logic [15:0] PHY_ID_HI_VAL  = 16'h0141;
  localparam logic [15:0] PHY_ID_LO_VAL  = 16'h0E20;
endpackage

// File: rtl/mii_stub.sv
module mii_stub
  import mac_csr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_value
);
  logic [DW-1:0] latched;

  always_ff @(posedge clk) begin
    if (rst) latched <= '0;
    else if (wr_en) latched <= wdata;
  end

  logic [MII_ADDR_W-1:0] reg_sel;
  assign reg_sel = latched[MII_ADDR_LO +: MII_ADDR_W];

  always_comb begin
    rd_value = '0;
    if (latched[MII_RD_BIT]) begin
      rd_value[MII_VLD_BIT] = 1'b1;
      case (reg_sel)
        PHY_STATUS: rd_value[15:0] = PHY_STATUS_VAL;
        PHY_ID_HI:  rd_value[15:0] = PHY_ID_HI_VAL;
        PHY_ID_LO:  rd_value[15:0] = PHY_ID_LO_VAL;
        default:    rd_value[15:0] = '0;
      endcase
    end
  end

  // R4
  mii_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_value != '0) |-> rd_value[MII_VLD_BIT]);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import mac_csr_pkg::*;
#(
  parameter int CW = CAUSE_W,
  parameter int MW = DW
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          cause_wr,
  input  logic          mask_wr,
  input  logic [MW-1:0] wdata,
  input  logic [CW-1:0] set_vec,
  output logic [CW-1:0] cause,
  output logic [MW-1:0] mask,
  output logic          irq
);
  logic [CW-1:0] keep;

  assign keep = cause_wr ? wdata[CW-1:0] : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause <= '0;
      mask  <= '0;
    end else begin
      cause <= (cause & keep) | set_vec;
      if (mask_wr) mask <= wdata;
    end
  end

  assign irq = |(cause & mask[CW-1:0]);

  // R6
  strobe_win_chk: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((cause & $past(set_vec)) == $past(set_vec)));
  // R5
  no_spont_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set_vec == '0) |=> ((cause & ~$past(cause)) == '0));
endmodule

// File: rtl/ptr_bank.sv
module ptr_bank
  import mac_csr_pkg::*;
#(
  parameter int              N    = 4,
  parameter int              W    = DW,
  parameter logic [AW-1:0]   BASE = 12'h480
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic          hit,
  output logic [W-1:0]  rdata,
  output logic [N*W-1:0] ptrs
);
  logic [N-1:0] sel;

  for (genvar i = 0; i < N; i++) begin : g_slot
    localparam logic [AW-1:0] SLOT_ADDR = BASE + AW'(4 * i);
    assign sel[i] = (addr == SLOT_ADDR);
    always_ff @(posedge clk) begin
      if (rst) ptrs[i*W +: W] <= '0;
      else if (wr_en && sel[i]) ptrs[i*W +: W] <= wdata;
    end
  end

  assign hit = |sel;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++)
      if (sel[i]) rdata = ptrs[i*W +: W];
  end

  // R11
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && hit) |=> $stable(ptrs));
endmodule

// File: rtl/mac_csr_top.sv
module mac_csr_top
  import mac_csr_pkg::*;
#(
  parameter int RX_Q  = 4,
  parameter int TX_Q  = 2,
  parameter int PTR_W = DW
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  output logic                req_ready,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_rdata,
  input  logic                rx_evt,
  input  logic                txhi_evt,
  input  logic                txlo_evt,
  output logic                irq,
  output logic [1:0]          rx_offset,
  output logic                tx_kick_hi,
  output logic                tx_kick_lo,
  output logic [RX_Q*PTR_W-1:0] rx_first_ptrs,
  output logic [RX_Q*PTR_W-1:0] rx_cur_ptrs,
  output logic [TX_Q*PTR_W-1:0] tx_cur_ptrs
);
  logic wr, rd;
  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;
  assign req_ready = 1'b1;

  // management stub
  logic [DW-1:0] mii_val;
  mii_stub u_mii (
    .clk(clk), .rst(rst),
    .wr_en(wr && req_addr == OFS_MII),
    .wdata(req_wdata), .rd_value(mii_val)
  );

  // interrupt cause and mask
  logic [CAUSE_W-1:0] set_vec, cause;
  logic [DW-1:0]      mask;
  always_comb begin
    set_vec = '0;
    set_vec[CAUSE_RX]   = rx_evt;
    set_vec[CAUSE_TXHI] = txhi_evt;
    set_vec[CAUSE_TXLO] = txlo_evt;
  end

  irq_ctrl #(.CW(CAUSE_W), .MW(DW)) u_irq (
    .clk(clk), .rst(rst),
    .cause_wr(wr && req_addr == OFS_CAUSE),
    .mask_wr(wr && req_addr == OFS_MASK),
    .wdata(req_wdata), .set_vec(set_vec),
    .cause(cause), .mask(mask), .irq(irq)
  );

  // ring pointer banks
  logic rxf_hit, rxc_hit, txc_hit;
  logic [PTR_W-1:0] rxf_rd, rxc_rd, txc_rd;

  ptr_bank #(.N(RX_Q), .W(PTR_W), .BASE(OFS_RXFIRST)) u_rxfirst (
    .clk(clk), .rst(rst), .wr_en(wr), .addr(req_addr),
    .wdata(req_wdata[PTR_W-1:0]), .hit(rxf_hit), .rdata(rxf_rd),
    .ptrs(rx_first_ptrs)
  );
  ptr_bank #(.N(RX_Q), .W(PTR_W), .BASE(OFS_RXCUR)) u_rxcur (
    .clk(clk), .rst(rst), .wr_en(wr), .addr(req_addr),
    .wdata(req_wdata[PTR_W-1:0]), .hit(rxc_hit), .rdata(rxc_rd),
    .ptrs(rx_cur_ptrs)
  );
  ptr_bank #(.N(TX_Q), .W(PTR_W), .BASE(OFS_TXCUR)) u_txcur (
    .clk(clk), .rst(rst), .wr_en(wr), .addr(req_addr),
    .wdata(req_wdata[PTR_W-1:0]), .hit(txc_hit), .rdata(txc_rd),
    .ptrs(tx_cur_ptrs)
  );

  // port configuration and transmit command
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_offset  <= 2'd0;
      tx_kick_hi <= 1'b0;
      tx_kick_lo <= 1'b0;
    end else begin
      if (wr && req_addr == OFS_PORTCFG)
        rx_offset <= req_wdata[OFFSET_SEL_BIT] ? 2'd2 : 2'd0;
      tx_kick_hi <= wr && req_addr == OFS_CMD && req_wdata[KICK_HI_BIT];
      tx_kick_lo <= wr && req_addr == OFS_CMD && req_wdata[KICK_LO_BIT];
    end
  end

  // read path
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (req_addr == OFS_MII)        rd_mux = mii_val;
    else if (req_addr == OFS_CAUSE) rd_mux = DW'(cause);
    else if (req_addr == OFS_MASK)  rd_mux = mask;
    else if (rxf_hit)               rd_mux = DW'(rxf_rd);
    else if (rxc_hit)               rd_mux = DW'(rxc_rd);
    else if (txc_hit)               rd_mux = DW'(txc_rd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rd_mux : '0;
    end
  end

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rd |=> rsp_valid);
  // R2
  rsp_source_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(rd));
  // R10
  kick_hi_src_chk: assert property (@(posedge clk) disable iff (rst)
    tx_kick_hi |-> $past(wr && req_addr == OFS_CMD && req_wdata[KICK_HI_BIT]));
  // R10
  kick_lo_src_chk: assert property (@(posedge clk) disable iff (rst)
    tx_kick_lo |-> $past(wr && req_addr == OFS_CMD && req_wdata[KICK_LO_BIT]));
endmodule

// File: tb/mac_csr_top_test.sv
`timescale 1ns/1ps
module mac_csr_top_test;
  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, irq, tx_kick_hi, tx_kick_lo;
  logic [31:0] rsp_rdata;
  logic rx_evt = 0, txhi_evt = 0, txlo_evt = 0;
  logic [1:0] rx_offset;
  logic [127:0] rx_first_ptrs, rx_cur_ptrs;
  logic [63:0] tx_cur_ptrs;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mac_csr_top uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rx_evt(rx_evt),
    .txhi_evt(txhi_evt), .txlo_evt(txlo_evt), .irq(irq),
    .rx_offset(rx_offset), .tx_kick_hi(tx_kick_hi), .tx_kick_lo(tx_kick_lo),
    .rx_first_ptrs(rx_first_ptrs), .rx_cur_ptrs(rx_cur_ptrs),
    .tx_cur_ptrs(tx_cur_ptrs)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check("R2 rsp_valid", 128'(rsp_valid), 128'(1));
    d = rsp_rdata;
  endtask

  task automatic strobe(input logic [3:0] p);
    @(negedge clk);
    rx_evt = p[0]; txhi_evt = p[2]; txlo_evt = p[3];
    @(negedge clk);
    rx_evt = 0; txhi_evt = 0; txlo_evt = 0;
  endtask

  function automatic logic [31:0] mii_exp(input logic [9:0] a);
    case (a)
      10'h021: return 32'h0800_000C;
      10'h041: return 32'h0800_0141;
      10'h061: return 32'h0800_0E20;
      default: return 32'h0800_0000;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [127:0] exp_rxf, exp_rxc;
    logic [63:0] exp_txc;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    check("R1 irq", 128'(irq), 0);
    check("R1 rx_offset", 128'(rx_offset), 0);
    check("R1 kicks", 128'({tx_kick_hi, tx_kick_lo}), 0);
    check("R1 rx_first", rx_first_ptrs, 0);
    check("R1 rx_cur", rx_cur_ptrs, 0);
    check("R1 tx_cur", 128'(tx_cur_ptrs), 0);
    check("R2 ready", 128'(req_ready), 1);
    check("R2 rsp idle", 128'(rsp_valid), 0);
    rd(12'h450, d); check("R1 cause", 128'(d), 0);
    rd(12'h458, d); check("R1 mask", 128'(d), 0);
    rd(12'h010, d); check("R1 mii", 128'(d), 0);
    @(negedge clk);
    check("R2 rsp drops", 128'(rsp_valid), 0);

    // R3 R4 management sweep
    for (int a = 0; a < 1024; a++) begin
      wr(12'h010, {5'b0, 1'b1, 10'(a), 16'h5A5A});
      rd(12'h010, d);
      check("R3 mii read", 128'(d), 128'(mii_exp(10'(a))));
    end
    wr(12'h010, {5'b0, 1'b0, 10'h021, 16'hFFFF});
    rd(12'h010, d); check("R4 no opcode", 128'(d), 0);

    // R8 port configuration
    wr(12'h408, 32'h1000_0000);
    check("R8 offset 2", 128'(rx_offset), 2);
    rd(12'h408, d); check("R8 reads zero", 128'(d), 0);
    wr(12'h408, 32'hEFFF_FFFF);
    check("R8 offset 0", 128'(rx_offset), 0);

    // R9 pointer banks
    exp_rxf = 0; exp_rxc = 0; exp_txc = 0;
    for (int i = 0; i < 4; i++) begin
      wr(12'(12'h480 + 4*i), 32'h1000_0000 + 32'(i * 32'h111));
      wr(12'(12'h4A0 + 4*i), 32'h2000_0000 + 32'(i * 32'h2222));
      exp_rxf[i*32 +: 32] = 32'h1000_0000 + 32'(i * 32'h111);
      exp_rxc[i*32 +: 32] = 32'h2000_0000 + 32'(i * 32'h2222);
    end
    for (int i = 0; i < 2; i++) begin
      wr(12'(12'h4E0 + 4*i), 32'hC000_0000 | 32'(i * 32'h3333 + 8));
      exp_txc[i*32 +: 32] = 32'hC000_0000 | 32'(i * 32'h3333 + 8);
    end
    for (int i = 0; i < 4; i++) begin
      rd(12'(12'h480 + 4*i), d); check("R9 rx_first readback", 128'(d), 128'(exp_rxf[i*32 +: 32]));
      rd(12'(12'h4A0 + 4*i), d); check("R9 rx_cur readback", 128'(d), 128'(exp_rxc[i*32 +: 32]));
    end
    for (int i = 0; i < 2; i++) begin
      rd(12'(12'h4E0 + 4*i), d); check("R9 tx_cur readback", 128'(d), 128'(exp_txc[i*32 +: 32]));
    end
    check("R9 rx_first out", rx_first_ptrs, exp_rxf);
    check("R9 rx_cur out", rx_cur_ptrs, exp_rxc);
    check("R9 tx_cur out", 128'(tx_cur_ptrs), 128'(exp_txc));

    // R11 unmapped and misaligned
    wr(12'h458, 32'h0000_0000);
    begin
      logic [11:0] bad [8] = '{12'h000, 12'h014, 12'h44C, 12'h482, 12'h490,
                               12'h4B0, 12'h4E8, 12'hFFC};
      foreach (bad[k]) begin
        wr(bad[k], 32'hFFFF_FFFF);
        rd(bad[k], d); check("R11 unmapped read", 128'(d), 0);
      end
    end
    check("R11 rx_first kept", rx_first_ptrs, exp_rxf);
    check("R11 rx_cur kept", rx_cur_ptrs, exp_rxc);
    check("R11 tx_cur kept", 128'(tx_cur_ptrs), 128'(exp_txc));
    check("R11 offset kept", 128'(rx_offset), 0);
    rd(12'h458, d); check("R11 mask kept", 128'(d), 0);
    rd(12'h450, d); check("R11 cause kept", 128'(d), 0);

    // R5 cause set by strobes, cleared by write-AND
    for (int p = 0; p < 16; p++) begin
      wr(12'h450, 32'h0);
      strobe(4'(p));
      rd(12'h450, d); check("R5 cause set", 128'(d), 128'(p & 4'b1101));
      wr(12'h450, 32'hFFFF_FFF5);
      rd(12'h450, d); check("R5 cause and", 128'(d), 128'(p & 4'b0101));
    end

    // R7 mask load and irq
    wr(12'h458, 32'hA5A5_0000);
    rd(12'h458, d); check("R7 mask readback", 128'(d), 128'(32'hA5A5_0000));
    for (int m = 0; m < 16; m++) begin
      for (int c = 0; c < 16; c++) begin
        wr(12'h450, 32'h0);
        strobe(4'(c));
        wr(12'h458, 32'hA5A5_0000 | 32'(m));
        check("R7 irq", 128'(irq), 128'(((c & 4'b1101) & m) != 0));
      end
    end
    wr(12'h458, 32'h0000_000F);
    strobe(4'b1101);
    check("R7 irq high", 128'(irq), 1);
    wr(12'h450, 32'h0);
    check("R7 irq falls", 128'(irq), 0);

    // R6 strobe beats same-cycle write-AND
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 12'h450; req_wdata = 32'h0;
    rx_evt = 1; txlo_evt = 1;
    @(negedge clk);
    req_valid = 0; req_write = 0; rx_evt = 0; txlo_evt = 0;
    check("R6 irq", 128'(irq), 1);
    rd(12'h450, d); check("R6 cause kept", 128'(d), 128'(4'b1001));

    // R10 transmit kicks
    wr(12'h448, 32'h0080_0000);
    check("R10 kick hi", 128'({tx_kick_hi, tx_kick_lo}), 128'(2'b10));
    @(negedge clk);
    check("R10 kick hi ends", 128'({tx_kick_hi, tx_kick_lo}), 0);
    wr(12'h448, 32'h0040_0000);
    check("R10 kick lo", 128'({tx_kick_hi, tx_kick_lo}), 128'(2'b01));
    @(negedge clk);
    check("R10 kick lo ends", 128'({tx_kick_hi, tx_kick_lo}), 0);
    wr(12'h448, 32'h00C0_0000);
    check("R10 kick both", 128'({tx_kick_hi, tx_kick_lo}), 128'(2'b11));
    wr(12'h448, 32'hFF3F_FFFF);
    check("R10 no kick", 128'({tx_kick_hi, tx_kick_lo}), 0);
    rd(12'h448, d); check("R10 reads zero", 128'(d), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule